// File: doc/BRIEF.md
# Firmware Hub Cycle Header Decoder

This block sits on the nibble-wide side of a firmware-hub style memory bus and decodes the header of each memory cycle. The header consists of a start code, a device-select nibble, a 28-bit address sent as seven nibbles, and a size nibble. A frame strobe opens each cycle. The decoder checks the start code and matches the device-select nibble against four strap pins. It then gathers the address and checks the size nibble. When all of these pass, it hands a single-cycle read or write request, with the address, to the data-phase logic that follows it.

A cycle meant for another device on the same bus is dropped without any response. So is a cycle carrying an illegal size, and the decoder returns to idle. The first device on a bus is strapped to ID 0000, and later devices count upward from there. After a read is accepted, the block holds a read-selected flag until the next frame strobe. While that flag is high, it lets the downstream logic enable the bus output drivers. The block has two active-low reset pins with identical effect. Either one resets the decoder, deselects a pending read and forces the output enable low at once, without waiting for a clock edge.

Top module: `fwh_hdr_decoder`

## Requirements
- R1: A cycle begins only on a clock where `frame_n` is low and `nib_in` carries 4'b1101 (memory read) or 4'b1110 (memory write); a low `frame_n` with any other code leaves the block idle with no request.
- R2: The nibble that follows the start code must equal `id_strap`; on a mismatch no request is issued and the rest of the cycle is ignored. Both strap 0000 and nonzero straps are accepted when they match.
- R3: The seven nibbles after the device-select nibble form `req_addr[27:0]`, most-significant nibble first.
- R4: The nibble after the seventh address nibble is the size field; only 4'b0000 is legal, and any other value drops the cycle with no request and a return to idle.
- R5: After a legal size nibble is sampled on a rising edge, `rd_req` (read code) or `wr_req` (write code) is high for exactly the one following clock cycle, with `req_addr` valid; the two never assert together.
- R6: A low `frame_n` in the middle of a header abandons that header, and the start code on that clock is evaluated afresh.
- R7: `rst_a_n` and `rst_b_n` act identically; either one low returns the decoder to idle, clears `rd_sel` and the request outputs, and a header cut by reset produces no request.
- R8: `oe` is low while either reset pin is low, without waiting for a clock edge, and `nib_out` is then 4'b0000.
- R9: `oe` is high, with `nib_out` equal to `drv_nib`, only while `rd_sel` is high and `drv_en` is high; an accepted write never raises `rd_sel` or `oe`.
- R10: `rd_sel` rises with `rd_req` and stays high until the next clock where `frame_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_a_n | input | 1 | Active-low reset, first pin |
| rst_b_n | input | 1 | Active-low reset, second pin |
| frame_n | input | 1 | Active-low frame strobe opening a cycle |
| nib_in | input | 4 | Nibble received from the bus |
| id_strap | input | 4 | Strapped device identity |
| drv_en | input | 1 | Drive request from data-phase logic |
| drv_nib | input | 4 | Nibble the data-phase logic wants to drive |
| nib_out | output | 4 | Nibble to the bus pad, zero when not enabled |
| oe | output | 1 | Pad output enable; low means high impedance |
| rd_sel | output | 1 | A read addressed to this device is pending |
| rd_req | output | 1 | One-cycle read request |
| wr_req | output | 1 | One-cycle write request |
| req_addr | output | 28 | Address of the accepted request |

## Verification
The main header path is tried with a read and a write under strap 0000, and with a read under a nonzero strap. Each uses an address whose seven nibbles are all different, so a swapped or shifted nibble shows up in `req_addr`. These headers are set against near-misses that differ in one field only: a wrong strap, a nonzero size, an unknown start code, or a frame strobe that restarts the header part-way. Each near-miss shows whether the block filters on that field alone. Reset is applied on each pin separately, both part-way through a header and while a read is selected with `drv_en` high. This tells apart the two pins and shows whether the enable drops at once or only at the next edge.

// File: rtl/fwh_hdr_pkg.sv
package fwh_hdr_pkg;

    localparam int NIB_W     = 4;
    localparam int ADDR_NIBS = 7;
    localparam int ADDR_W    = NIB_W * ADDR_NIBS;
    localparam int CNT_W     = $clog2(ADDR_NIBS);

    localparam logic [NIB_W-1:0] CODE_MEM_RD = 4'b1101;
    localparam logic [NIB_W-1:0] CODE_MEM_WR = 4'b1110;
    localparam logic [NIB_W-1:0] SIZE_LEGAL  = 4'b0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IDSEL,
        ST_ADDR,
        ST_SIZE,
        ST_HOLD
    } hdr_state_e;

    typedef struct packed {
        hdr_state_e         state;
        logic               is_wr;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  addr;
        logic               rd_req;
        logic               wr_req;
    } hdr_regs_s;

endpackage

// File: rtl/fwh_rst_merge.sv
module fwh_rst_merge #(
    parameter int N_PINS = 2
) (
    input  logic [N_PINS-1:0] pin_n,
    output logic              rst_n
);
    logic [N_PINS:0] chain;

    assign chain[0] = 1'b1;

    // Every pin has equal weight: any one low pulls the merged reset low.
    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_and
            assign chain[i+1] = chain[i] & pin_n[i];
        end
    endgenerate

    assign rst_n = chain[N_PINS];
endmodule

// File: rtl/fwh_hdr_fsm.sv
module fwh_hdr_fsm
    import fwh_hdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [NIB_W-1:0]  nib_in,
    input  logic [NIB_W-1:0]  id_strap,
    output logic              rd_req,
    output logic              wr_req,
    output logic [ADDR_W-1:0] req_addr,
    output logic              rd_sel
);
    hdr_regs_s r_d, r_q;

    logic is_start;
    assign is_start = (nib_in == CODE_MEM_RD) || (nib_in == CODE_MEM_WR);

    always_comb begin
        r_d        = r_q;
        r_d.rd_req = 1'b0;
        r_d.wr_req = 1'b0;
        if (!frame_n) begin
            // A frame strobe always restarts decoding, whatever the state.
            r_d.state = is_start ? ST_IDSEL : ST_IDLE;
            r_d.is_wr = (nib_in == CODE_MEM_WR);
            r_d.cnt   = '0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: r_d.state = ST_IDLE;
                ST_IDSEL: begin
                    r_d.state = (nib_in == id_strap) ? ST_ADDR : ST_IDLE;
                    r_d.cnt   = '0;
                end
                ST_ADDR: begin
                    r_d.addr = {r_q.addr[ADDR_W-NIB_W-1:0], nib_in};
                    r_d.cnt  = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(ADDR_NIBS - 1)) r_d.state = ST_SIZE;
                end
                ST_SIZE: begin
                    if (nib_in == SIZE_LEGAL) begin
                        r_d.state  = ST_HOLD;
                        r_d.rd_req = !r_q.is_wr;
                        r_d.wr_req = r_q.is_wr;
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end
                ST_HOLD: r_d.state = ST_HOLD;
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, is_wr: 1'b0, cnt: '0, addr: '0,
                     rd_req: 1'b0, wr_req: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req   = r_q.rd_req;
    assign wr_req   = r_q.wr_req;
    assign req_addr = r_q.addr;
    assign rd_sel   = (r_q.state == ST_HOLD) && !r_q.is_wr;

    // R5: a request lasts one cycle only
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || wr_req) |=> !(rd_req || wr_req));
    // R5: read and write requests are exclusive
    a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));
    // R4: illegal size leads to idle with no request
    a_r4_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SIZE && frame_n && nib_in != SIZE_LEGAL)
        |=> (r_q.state == ST_IDLE && !rd_req && !wr_req));
    // R2: strap mismatch drops the cycle
    a_r2_id_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDSEL && frame_n && nib_in != id_strap)
        |=> (r_q.state == ST_IDLE));
    // R6: a frame strobe with a read code restarts at the select nibble
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_n && nib_in == CODE_MEM_RD)
        |=> (r_q.state == ST_IDSEL && !r_q.is_wr));
    // R10: read selection ends on the next frame strobe
    a_r10_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && !frame_n) |=> !rd_sel);
endmodule

// File: rtl/fwh_pad_gate.sv
module fwh_pad_gate #(
    parameter int W = 4
) (
    input  logic         rst_n,
    input  logic         sel_rd,
    input  logic         drv_en,
    input  logic [W-1:0] drv_nib,
    output logic         oe,
    output logic [W-1:0] nib_out
);
    // The reset term is combinational so the pad releases at once.
    assign oe      = rst_n && sel_rd && drv_en;
    assign nib_out = oe ? drv_nib : '0;
endmodule

// File: rtl/fwh_hdr_decoder.sv
module fwh_hdr_decoder
    import fwh_hdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_a_n,
    input  logic              rst_b_n,
    input  logic              frame_n,
    input  logic [NIB_W-1:0]  nib_in,
    input  logic [NIB_W-1:0]  id_strap,
    input  logic              drv_en,
    input  logic [NIB_W-1:0]  drv_nib,
    output logic [NIB_W-1:0]  nib_out,
    output logic              oe,
    output logic              rd_sel,
    output logic              rd_req,
    output logic              wr_req,
    output logic [ADDR_W-1:0] req_addr
);
    logic rst_n;

    fwh_rst_merge #(.N_PINS(2)) u_rst (
        .pin_n ({rst_b_n, rst_a_n}),
        .rst_n (rst_n)
    );

    fwh_hdr_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .nib_in   (nib_in),
        .id_strap (id_strap),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .req_addr (req_addr),
        .rd_sel   (rd_sel)
    );

    fwh_pad_gate #(.W(NIB_W)) u_pad (
        .rst_n   (rst_n),
        .sel_rd  (rd_sel),
        .drv_en  (drv_en),
        .drv_nib (drv_nib),
        .oe      (oe),
        .nib_out (nib_out)
    );

    // R9: the pad is never enabled for a write or without a selected read
    a_r9_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (rd_sel && !wr_req));
endmodule

// File: tb/fwh_hdr_decoder_tb.sv
`timescale 1ns/1ps
module fwh_hdr_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_a_n = 1'b0, rst_b_n = 1'b0;
    logic        frame_n = 1'b1;
    logic [3:0]  nib_in = 4'h0, id_strap = 4'h0;
    logic        drv_en = 1'b0;
    logic [3:0]  drv_nib = 4'h0;
    logic [3:0]  nib_out;
    logic        oe, rd_sel, rd_req, wr_req;
    logic [27:0] req_addr;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fwh_hdr_decoder u_dut (
        .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n), .frame_n(frame_n),
        .nib_in(nib_in), .id_strap(id_strap), .drv_en(drv_en), .drv_nib(drv_nib),
        .nib_out(nib_out), .oe(oe), .rd_sel(rd_sel), .rd_req(rd_req),
        .wr_req(wr_req), .req_addr(req_addr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic f, input logic [3:0] n);
        @(negedge clk);
        frame_n = f;
        nib_in  = n;
    endtask

    // Drives start, id, seven address nibbles and size; then samples after
    // the edge that captures the size nibble.
    task automatic header(input logic [3:0] code, input logic [3:0] id,
                          input logic [27:0] addr, input logic [3:0] size);
        put(1'b0, code);
        put(1'b1, id);
        for (int i = 6; i >= 0; i--) put(1'b1, addr[i*4 +: 4]);
        put(1'b1, size);
        @(posedge clk); #1;
    endtask

    task automatic idle_bus();
        put(1'b1, 4'h0);
    endtask

    task automatic t_reset_state();
        chk(!oe && !rd_req && !wr_req && !rd_sel, "R7 reset outputs",
            {oe, rd_req, wr_req, rd_sel}, 0);
        chk(nib_out == 4'h0, "R8 nib_out in reset", nib_out, 0);
    endtask

    task automatic t_read_boot();
        id_strap = 4'h0;
        header(4'b1101, 4'h0, 28'h1234567, 4'h0);
        chk(rd_req && !wr_req, "R1 R5 read request", {rd_req, wr_req}, 2'b10);
        chk(req_addr == 28'h1234567, "R3 address order", req_addr, 28'h1234567);
        chk(rd_sel, "R10 rd_sel rises", rd_sel, 1);
        @(posedge clk); #1;
        chk(!rd_req, "R5 pulse width", rd_req, 0);
        chk(rd_sel, "R10 rd_sel held", rd_sel, 1);
        drv_en = 1'b1; drv_nib = 4'hA; #1;
        chk(oe && nib_out == 4'hA, "R9 drive enabled", {oe, nib_out}, 5'h1A);
        drv_en = 1'b0; #1;
        chk(!oe, "R9 drv_en low", oe, 0);
        put(1'b0, 4'h0);
        @(posedge clk); #1;
        chk(!rd_sel, "R10 deselect on frame", rd_sel, 1'b0);
        chk(!rd_req && !wr_req, "R1 unknown code no request", {rd_req, wr_req}, 0);
        idle_bus();
    endtask

    task automatic t_write_boot();
        id_strap = 4'h0;
        header(4'b1110, 4'h0, 28'hFEDCBA9, 4'h0);
        chk(wr_req && !rd_req, "R5 write request", {rd_req, wr_req}, 2'b01);
        chk(req_addr == 28'hFEDCBA9, "R3 write address", req_addr, 28'hFEDCBA9);
        drv_en = 1'b1; #1;
        chk(!rd_sel && !oe, "R9 write no drive", {rd_sel, oe}, 0);
        drv_en = 1'b0;
        @(posedge clk); #1;
        chk(!wr_req, "R5 write pulse width", wr_req, 0);
        idle_bus();
    endtask

    task automatic t_strap_nonzero();
        id_strap = 4'h3;
        header(4'b1101, 4'h3, 28'h0A1B2C3, 4'h0);
        chk(rd_req && req_addr == 28'h0A1B2C3, "R2 nonzero strap match",
            req_addr, 28'h0A1B2C3);
        idle_bus();
        header(4'b1101, 4'h2, 28'h0A1B2C3, 4'h0);
        chk(!rd_req && !wr_req && !rd_sel, "R2 strap mismatch",
            {rd_req, wr_req, rd_sel}, 0);
        idle_bus();
        id_strap = 4'h0;
    endtask

    task automatic t_bad_size();
        header(4'b1110, 4'h0, 28'h5555555, 4'h1);
        chk(!rd_req && !wr_req, "R4 size 0001", {rd_req, wr_req}, 0);
        header(4'b1101, 4'h0, 28'h5555555, 4'h8);
        chk(!rd_req && !wr_req && !rd_sel, "R4 size 1000",
            {rd_req, wr_req, rd_sel}, 0);
        idle_bus();
    endtask

    task automatic t_unknown_start();
        header(4'b1100, 4'h0, 28'h1111111, 4'h0);
        chk(!rd_req && !wr_req, "R1 code 1100 ignored", {rd_req, wr_req}, 0);
        idle_bus();
    endtask

    task automatic t_restart();
        put(1'b0, 4'b1101);
        put(1'b1, 4'h0);
        put(1'b1, 4'h9);
        put(1'b1, 4'h9);
        header(4'b1110, 4'h0, 28'h7654321, 4'h0);
        chk(wr_req && !rd_req, "R6 restart as write", {rd_req, wr_req}, 2'b01);
        chk(req_addr == 28'h7654321, "R6 restart address", req_addr, 28'h7654321);
        idle_bus();
    endtask

    task automatic t_reset_pins();
        // reset on pin B cuts a header
        put(1'b0, 4'b1101);
        put(1'b1, 4'h0);
        put(1'b1, 4'h1);
        rst_b_n = 1'b0;
        put(1'b1, 4'h2);
        rst_b_n = 1'b1;
        for (int i = 0; i < 5; i++) put(1'b1, 4'h0);
        put(1'b1, 4'h0);
        @(posedge clk); #1;
        chk(!rd_req && !wr_req, "R7 pin B cuts header", {rd_req, wr_req}, 0);
        idle_bus();
        // pin A during a selected read with drive enabled
        header(4'b1101, 4'h0, 28'h2468ACE, 4'h0);
        drv_en = 1'b1; drv_nib = 4'h5;
        @(negedge clk); #1;
        chk(oe, "R9 oe before reset", oe, 1);
        rst_a_n = 1'b0; #0.5;
        chk(!oe && nib_out == 4'h0, "R8 pin A tri-states at once",
            {oe, nib_out}, 0);
        chk(!rd_sel, "R7 pin A deselects", rd_sel, 0);
        @(negedge clk); rst_a_n = 1'b1;
        @(posedge clk); #1;
        chk(!oe && !rd_sel, "R7 stays idle after release", {oe, rd_sel}, 0);
        // pin B alone during a selected read
        drv_en = 1'b0;
        header(4'b1101, 4'h0, 28'h1357BDF, 4'h0);
        drv_en = 1'b1;
        #0.5;
        rst_b_n = 1'b0; #0.5;
        chk(!oe && !rd_sel && !rd_req, "R8 pin B tri-states", {oe, rd_sel, rd_req}, 0);
        @(negedge clk); rst_b_n = 1'b1; drv_en = 1'b0;
        idle_bus();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset_state();
        @(negedge clk); rst_a_n = 1'b1; rst_b_n = 1'b1;
        idle_bus();
        t_read_boot();
        t_write_boot();
        t_strap_nonzero();
        t_bad_size();
        t_unknown_start();
        t_restart();
        t_reset_pins();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule